// File: doc/BRIEF.md
# Single-Operand Address Sequencer

This block runs the operand phase of a one-operand instruction for a 16-bit CPU whose general registers are words in memory. It is started with a 2-bit addressing mode, a 4-bit register number, an operation kind, the current workspace base and the current program counter. It works out one effective address, reading the register word and an extension word that follows the opcode when the mode needs them, and applies the post-increment side effect once. It then reads the operand at that address, hands it to an external compute stage and writes the result back to the same address.

Branch kinds use only the address. A plain branch loads it into the program counter. A branch with link first stores the program counter into register 11 and then loads it. A write-only kind (clear, set to ones) skips the operand read but still writes the result. Every memory access is held until the memory answers with ready.

Top module: `operand_sequencer`

## Requirements
- R1: Mode 00 (register) uses effective address wp + 2·n and fetches no extension word.
- R2: Mode 01 (indirect) reads the register word at wp + 2·n and uses its contents as the effective address.
- R3: Mode 11 (indirect, auto-increment) uses the old register contents as the address and writes contents + 2 back to the register exactly once, before the operand read.
- R4: Mode 10 with n = 0 (absolute) reads the extension word at the current PC, uses it as the address, and pulses pc_load with PC + 2.
- R5: Mode 10 with n ≠ 0 (indexed) fetches the extension word first, then the register word, and uses their sum modulo 2^16 as the address.
- R6: Kind 00 (read-modify-write) reads the operand at the effective address and holds it on cmp_operand with cmp_valid until cmp_ready. It then writes cmp_result to that same address.
- R7: Kind 01 (write only) performs no operand read, offers 0 to the compute stage and writes cmp_result to the effective address.
- R8: Kind 10 (branch) performs no operand read, no compute handshake and no write, and pulses pc_load with the effective address in its final cycle.
- R9: Kind 11 (branch with link) writes the program counter (already advanced past any extension word) to wp + 22, then pulses pc_load with the effective address.
- R10: A memory request keeps its address, direction and write data unchanged until mem_ready; mem_rd and mem_wr are never high together.
- R11: busy rises the cycle after an accepted start and stays high through the single-cycle done pulse; start is ignored while busy.
- R12: After reset, busy, done, mem_rd, mem_wr, cmp_valid and pc_load are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an operation (taken only when idle) |
| mode_i | input | 2 | Addressing mode |
| reg_i | input | 4 | Register number n |
| kind_i | input | 2 | 00 modify, 01 write only, 10 branch, 11 branch with link |
| wp_i | input | 16 | Workspace base address |
| pc_i | input | 16 | Program counter (address of the word after the opcode) |
| busy | output | 1 | Operation in progress |
| done | output | 1 | Final-cycle pulse |
| mem_addr | output | 16 | Memory byte address |
| mem_rd | output | 1 | Read request |
| mem_wr | output | 1 | Write request |
| mem_wdata | output | 16 | Write data |
| mem_rdata | input | 16 | Read data, valid with mem_ready |
| mem_ready | input | 1 | Access complete |
| cmp_valid | output | 1 | Operand offered to compute stage |
| cmp_operand | output | 16 | Operand value |
| cmp_result | input | 16 | Result, valid with cmp_ready |
| cmp_ready | input | 1 | Compute stage accepts and returns the result |
| pc_load | output | 1 | Load pc_value into the program counter |
| pc_value | output | 16 | New program counter |

## Verification
On every cycle the assertions check the request hold rule, the exclusion of read and write, the stability of the operand offered to the compute stage, and that the result write goes to the address the operand read used. They also check that the auto-increment write happens at most once per operation, that branch kinds never start a compute handshake, and the shape of the busy and done signals. Whether each mode produces the right address arithmetic, the right order of register, extension and operand accesses, the link value and the new program counter can only be shown by the bench's directed scenarios. Those scenarios compare the full access log against values derived from the requirements.

// File: rtl/opseq_pkg.sv
package opseq_pkg;

  typedef enum logic [3:0] {
    S_IDLE,
    S_EXT,
    S_PTR,
    S_INC,
    S_OPR,
    S_CMP,
    S_RES,
    S_LINK,
    S_FIN
  } st_e;

  typedef enum logic [1:0] {
    K_RMW   = 2'b00,
    K_WONLY = 2'b01,
    K_BR    = 2'b10,
    K_BRL   = 2'b11
  } kind_e;

  localparam logic [1:0] M_REG = 2'b00;
  localparam logic [1:0] M_IND = 2'b01;
  localparam logic [1:0] M_SYM = 2'b10;
  localparam logic [1:0] M_AUT = 2'b11;

endpackage

// File: rtl/opseq_ctrl.sv
module opseq_ctrl
  import opseq_pkg::*;
#(
  parameter int RW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [1:0]    mode_i,
  input  logic [RW-1:0] reg_i,
  input  logic [1:0]    kind_i,
  input  logic          acc_done,
  input  logic          cmp_ready,
  output st_e           state,
  output logic          busy,
  output logic          done,
  output logic          fin_branch,
  output logic          br_kind
);

  st_e        nxt;
  logic [1:0] mode_q;
  kind_e      kind_q;
  logic       rzero_q;

  function automatic st_e after_ea(input kind_e k);
    case (k)
      K_RMW:   return S_OPR;
      K_WONLY: return S_CMP;
      K_BR:    return S_FIN;
      default: return S_LINK;
    endcase
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      mode_q  <= M_REG;
      kind_q  <= K_RMW;
      rzero_q <= 1'b0;
    end else begin
      state <= nxt;
      if (state == S_IDLE && start) begin
        mode_q  <= mode_i;
        kind_q  <= kind_e'(kind_i);
        rzero_q <= (reg_i == '0);
      end
    end
  end

  always_comb begin
    nxt = state;
    case (state)
      S_IDLE: if (start) begin
        case (mode_i)
          M_REG:   nxt = after_ea(kind_e'(kind_i));
          M_SYM:   nxt = S_EXT;
          default: nxt = S_PTR;
        endcase
      end
      S_EXT:  if (acc_done) nxt = rzero_q ? after_ea(kind_q) : S_PTR;
      S_PTR:  if (acc_done) nxt = (mode_q == M_AUT) ? S_INC : after_ea(kind_q);
      S_INC:  if (acc_done) nxt = after_ea(kind_q);
      S_OPR:  if (acc_done) nxt = S_CMP;
      S_CMP:  if (cmp_ready) nxt = S_RES;
      S_RES:  if (acc_done) nxt = S_FIN;
      S_LINK: if (acc_done) nxt = S_FIN;
      S_FIN:  nxt = S_IDLE;
      default: nxt = S_IDLE;
    endcase
  end

  assign busy       = (state != S_IDLE);
  assign done       = (state == S_FIN);
  assign fin_branch = done && kind_q[1];
  assign br_kind    = busy && kind_q[1];

endmodule

// File: rtl/opseq_dpath.sv
module opseq_dpath
  import opseq_pkg::*;
#(
  parameter int DW         = 16,
  parameter int RW         = 4,
  parameter int WORD_BYTES = 2,
  parameter int LINK_IDX   = 11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  st_e           state,
  input  logic          accept,
  input  logic [RW-1:0] reg_i,
  input  logic [DW-1:0] wp_i,
  input  logic [DW-1:0] pc_i,
  input  logic          acc_done,
  input  logic          cmp_ready,
  input  logic [DW-1:0] cmp_result,
  input  logic [DW-1:0] mem_rdata,
  input  logic          fin_branch,
  output logic [DW-1:0] mem_addr,
  output logic          mem_rd,
  output logic          mem_wr,
  output logic [DW-1:0] mem_wdata,
  output logic          cmp_valid,
  output logic [DW-1:0] cmp_operand,
  output logic          pc_load,
  output logic [DW-1:0] pc_value,
  output logic [DW-1:0] ea_q
);

  localparam int               SHIFT  = $clog2(WORD_BYTES);
  localparam logic [DW-1:0]    STEP   = DW'(WORD_BYTES);
  localparam logic [RW-1:0]    LINK_N = RW'(LINK_IDX);

  logic [DW-1:0] wp_q, pc_q, ext_q, ptr_q, opnd_q, res_q;
  logic [RW-1:0] idx_q;
  logic          ext_seen_q;

  // register n lives at wp + n*WORD_BYTES
  function automatic logic [DW-1:0] reg_addr(input logic [DW-1:0] wp,
                                             input logic [RW-1:0] n);
    return wp + (DW'(n) << SHIFT);
  endfunction

  function automatic logic [DW-1:0] bump(input logic [DW-1:0] v);
    return v + STEP;
  endfunction

  function automatic logic [DW-1:0] idx_ea(input logic [DW-1:0] base,
                                           input logic [DW-1:0] disp,
                                           input logic          use_disp);
    return use_disp ? base + disp : base;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp_q       <= '0;
      pc_q       <= '0;
      ext_q      <= '0;
      ptr_q      <= '0;
      opnd_q     <= '0;
      res_q      <= '0;
      idx_q      <= '0;
      ea_q       <= '0;
      ext_seen_q <= 1'b0;
    end else begin
      if (accept) begin
        wp_q       <= wp_i;
        pc_q       <= pc_i;
        idx_q      <= reg_i;
        ea_q       <= reg_addr(wp_i, reg_i);
        opnd_q     <= '0;
        ext_seen_q <= 1'b0;
      end
      if (state == S_EXT && acc_done) begin
        ext_q      <= mem_rdata;
        ea_q       <= mem_rdata;
        pc_q       <= bump(pc_q);
        ext_seen_q <= 1'b1;
      end
      if (state == S_PTR && acc_done) begin
        ptr_q <= mem_rdata;
        ea_q  <= idx_ea(mem_rdata, ext_q, ext_seen_q);
      end
      if (state == S_OPR && acc_done) opnd_q <= mem_rdata;
      if (state == S_CMP && cmp_ready) res_q <= cmp_result;
    end
  end

  always_comb begin
    mem_addr  = '0;
    mem_wdata = '0;
    mem_rd    = 1'b0;
    mem_wr    = 1'b0;
    case (state)
      S_EXT: begin
        mem_addr = pc_q;
        mem_rd   = 1'b1;
      end
      S_PTR: begin
        mem_addr = reg_addr(wp_q, idx_q);
        mem_rd   = 1'b1;
      end
      S_INC: begin
        mem_addr  = reg_addr(wp_q, idx_q);
        mem_wdata = bump(ptr_q);
        mem_wr    = 1'b1;
      end
      S_OPR: begin
        mem_addr = ea_q;
        mem_rd   = 1'b1;
      end
      S_RES: begin
        mem_addr  = ea_q;
        mem_wdata = res_q;
        mem_wr    = 1'b1;
      end
      S_LINK: begin
        mem_addr  = reg_addr(wp_q, LINK_N);
        mem_wdata = pc_q;
        mem_wr    = 1'b1;
      end
      default: ;
    endcase
  end

  assign cmp_valid   = (state == S_CMP);
  assign cmp_operand = opnd_q;

  always_comb begin
    pc_load  = 1'b0;
    pc_value = '0;
    if (state == S_EXT && acc_done) begin
      pc_load  = 1'b1;
      pc_value = bump(pc_q);
    end else if (fin_branch) begin
      pc_load  = 1'b1;
      pc_value = ea_q;
    end
  end

endmodule

// File: rtl/operand_sequencer.sv
module operand_sequencer
  import opseq_pkg::*;
#(
  parameter int DW         = 16,
  parameter int RW         = 4,
  parameter int WORD_BYTES = 2,
  parameter int LINK_IDX   = 11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [1:0]    mode_i,
  input  logic [RW-1:0] reg_i,
  input  logic [1:0]    kind_i,
  input  logic [DW-1:0] wp_i,
  input  logic [DW-1:0] pc_i,
  output logic          busy,
  output logic          done,
  output logic [DW-1:0] mem_addr,
  output logic          mem_rd,
  output logic          mem_wr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  input  logic          mem_ready,
  output logic          cmp_valid,
  output logic [DW-1:0] cmp_operand,
  input  logic [DW-1:0] cmp_result,
  input  logic          cmp_ready,
  output logic          pc_load,
  output logic [DW-1:0] pc_value
);

  st_e           state;
  logic          fin_branch;
  logic          br_kind;
  logic [DW-1:0] ea_q;

  // named events for the checker
  logic acc_done, ev_ptr_inc, ev_opr_rd, ev_res_wr, accept;
  assign acc_done   = (mem_rd || mem_wr) && mem_ready;
  assign accept     = (state == S_IDLE) && start;
  assign ev_ptr_inc = (state == S_INC) && acc_done;
  assign ev_opr_rd  = (state == S_OPR) && acc_done;
  assign ev_res_wr  = (state == S_RES) && acc_done;

  opseq_ctrl #(.RW(RW)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .mode_i     (mode_i),
    .reg_i      (reg_i),
    .kind_i     (kind_i),
    .acc_done   (acc_done),
    .cmp_ready  (cmp_ready),
    .state      (state),
    .busy       (busy),
    .done       (done),
    .fin_branch (fin_branch),
    .br_kind    (br_kind)
  );

  opseq_dpath #(
    .DW(DW), .RW(RW), .WORD_BYTES(WORD_BYTES), .LINK_IDX(LINK_IDX)
  ) u_dpath (
    .clk         (clk),
    .rst_n       (rst_n),
    .state       (state),
    .accept      (accept),
    .reg_i       (reg_i),
    .wp_i        (wp_i),
    .pc_i        (pc_i),
    .acc_done    (acc_done),
    .cmp_ready   (cmp_ready),
    .cmp_result  (cmp_result),
    .mem_rdata   (mem_rdata),
    .fin_branch  (fin_branch),
    .mem_addr    (mem_addr),
    .mem_rd      (mem_rd),
    .mem_wr      (mem_wr),
    .mem_wdata   (mem_wdata),
    .cmp_valid   (cmp_valid),
    .cmp_operand (cmp_operand),
    .pc_load     (pc_load),
    .pc_value    (pc_value),
    .ea_q        (ea_q)
  );

endmodule

// File: rtl/opseq_chk.sv
module opseq_chk #(
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic          busy,
  input logic          done,
  input logic [DW-1:0] mem_addr,
  input logic          mem_rd,
  input logic          mem_wr,
  input logic [DW-1:0] mem_wdata,
  input logic          mem_ready,
  input logic          cmp_valid,
  input logic [DW-1:0] cmp_operand,
  input logic          cmp_ready,
  input logic          pc_load,
  input logic          ev_ptr_inc,
  input logic          ev_opr_rd,
  input logic          ev_res_wr,
  input logic          br_kind
);

  logic [DW-1:0] opr_addr_q;
  logic          have_opr_q;
  logic          inc_seen_q;

  always_ff @(posedge clk) begin
    if (!rst_n || done) begin
      opr_addr_q <= '0;
      have_opr_q <= 1'b0;
      inc_seen_q <= 1'b0;
    end else begin
      if (ev_opr_rd) begin
        opr_addr_q <= mem_addr;
        have_opr_q <= 1'b1;
      end
      if (ev_ptr_inc) inc_seen_q <= 1'b1;
    end
  end

  p_rdwr_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd && mem_wr));

  p_req_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd || mem_wr) && !mem_ready |=>
      mem_rd == $past(mem_rd) && mem_wr == $past(mem_wr) &&
      $stable(mem_addr) && $stable(mem_wdata));

  p_cmp_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_valid && !cmp_ready |=> cmp_valid && $stable(cmp_operand));

  p_same_loc_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ev_res_wr && have_opr_q |-> mem_addr == opr_addr_q);

  p_inc_once_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ev_ptr_inc |-> !inc_seen_q);

  p_no_cmp_branch_r8: assert property (@(posedge clk) disable iff (!rst_n)
    br_kind |-> !cmp_valid);

  p_busy_rise_r11: assert property (@(posedge clk) disable iff (!rst_n)
    start && !busy |=> busy);

  p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> busy ##1 (!done && !busy));

  p_pcload_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
    pc_load |-> busy);

endmodule

bind operand_sequencer opseq_chk #(.DW(DW)) u_chk (.*);

// File: tb/test_operand_sequencer.sv
module test_operand_sequencer;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [1:0]  mode_i = 2'b00;
  logic [3:0]  reg_i = 4'd0;
  logic [1:0]  kind_i = 2'b00;
  logic [15:0] wp_i = 16'h0040;
  logic [15:0] pc_i = 16'h0080;
  logic        busy, done, mem_rd, mem_wr, cmp_valid, pc_load;
  logic [15:0] mem_addr, mem_wdata, cmp_operand, pc_value;
  logic [15:0] mem_rdata = '0;
  logic        mem_ready = 1'b0;
  logic [15:0] cmp_result = '0;
  logic        cmp_ready = 1'b0;

  always #5 clk = ~clk;

  operand_sequencer i_operand_sequencer (.*);

  int checks = 0;
  int failures = 0;

  logic [15:0] mem [0:127];
  int          ws = 0;
  int          wcnt = 0;
  int          fn_sel = 0;

  logic [15:0] lg_addr [0:15];
  logic [15:0] lg_data [0:15];
  logic        lg_wr   [0:15];
  int          lg_n = 0;
  logic [15:0] pcl [0:3];
  int          pcl_n = 0;
  int          done_cnt = 0;
  logic [15:0] seen_opnd = '0;

  // memory model with programmable wait states
  always @(posedge clk) begin
    mem_ready <= 1'b0;
    if ((mem_rd || mem_wr) && !mem_ready) begin
      if (wcnt >= ws) begin
        wcnt <= 0;
        mem_ready <= 1'b1;
        if (mem_wr) mem[mem_addr[7:1]] <= mem_wdata;
        else        mem_rdata <= mem[mem_addr[7:1]];
        if (lg_n < 16) begin
          lg_addr[lg_n] <= mem_addr;
          lg_wr[lg_n]   <= mem_wr;
          lg_data[lg_n] <= mem_wr ? mem_wdata : mem[mem_addr[7:1]];
        end
        lg_n <= lg_n + 1;
      end else begin
        wcnt <= wcnt + 1;
      end
    end
  end

  // compute stage model: 0 increment, 1 invert, 2 all ones
  always @(posedge clk) begin
    cmp_ready <= 1'b0;
    if (cmp_valid && !cmp_ready) begin
      cmp_ready  <= 1'b1;
      seen_opnd  <= cmp_operand;
      cmp_result <= (fn_sel == 0) ? cmp_operand + 16'd1 :
                    (fn_sel == 1) ? ~cmp_operand : 16'hFFFF;
    end
  end

  always @(posedge clk) begin
    if (pc_load) begin
      if (pcl_n < 4) pcl[pcl_n] <= pc_value;
      pcl_n <= pcl_n + 1;
    end
    if (done) done_cnt <= done_cnt + 1;
  end

  task automatic check(input string req, input logic [15:0] act,
                       input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic chk_log(input string req, input int i, input logic wr,
                         input logic [15:0] a, input logic [15:0] d);
    check(req, {15'd0, lg_wr[i]}, {15'd0, wr});
    check(req, lg_addr[i], a);
    check(req, lg_data[i], d);
  endtask

  task automatic run_op(input logic [1:0] m, input logic [3:0] n,
                        input logic [1:0] k);
    lg_n = 0; pcl_n = 0; done_cnt = 0;
    @(negedge clk);
    mode_i = m; reg_i = n; kind_i = k; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int t = 0; t < 200 && !done; t++) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset;
    check("R12 busy", {15'd0, busy}, 16'd0);
    check("R12 done", {15'd0, done}, 16'd0);
    check("R12 rd/wr", {14'd0, mem_rd, mem_wr}, 16'd0);
    check("R12 cmp/pc", {14'd0, cmp_valid, pc_load}, 16'd0);
  endtask

  task automatic t_register;
    mem[16'h004A >> 1] = 16'h1234; fn_sel = 0; ws = 0;
    run_op(2'b00, 4'd5, 2'b00);
    check("R1 count", 16'(lg_n), 16'd2);
    chk_log("R1 read", 0, 1'b0, 16'h004A, 16'h1234);
    chk_log("R6 write", 1, 1'b1, 16'h004A, 16'h1235);
    check("R1 no pc", 16'(pcl_n), 16'd0);
  endtask

  task automatic t_indirect;
    mem[16'h0046 >> 1] = 16'h00A0; mem[16'h00A0 >> 1] = 16'h00FF; fn_sel = 1;
    run_op(2'b01, 4'd3, 2'b00);
    check("R2 count", 16'(lg_n), 16'd3);
    chk_log("R2 reg", 0, 1'b0, 16'h0046, 16'h00A0);
    chk_log("R2 opr", 1, 1'b0, 16'h00A0, 16'h00FF);
    chk_log("R6 res", 2, 1'b1, 16'h00A0, 16'hFF00);
  endtask

  task automatic t_autoinc;
    mem[16'h004E >> 1] = 16'h00B0; mem[16'h00B0 >> 1] = 16'h0005;
    fn_sel = 0; ws = 2;
    run_op(2'b11, 4'd7, 2'b00);
    ws = 0;
    check("R3 count", 16'(lg_n), 16'd4);
    chk_log("R3 ptr", 0, 1'b0, 16'h004E, 16'h00B0);
    chk_log("R3 inc", 1, 1'b1, 16'h004E, 16'h00B2);
    chk_log("R3 opr", 2, 1'b0, 16'h00B0, 16'h0005);
    chk_log("R10 res waited", 3, 1'b1, 16'h00B0, 16'h0006);
  endtask

  task automatic t_absolute;
    mem[16'h0080 >> 1] = 16'h00C0; mem[16'h00C0 >> 1] = 16'h0007; fn_sel = 0;
    run_op(2'b10, 4'd0, 2'b00);
    check("R4 count", 16'(lg_n), 16'd3);
    chk_log("R4 ext", 0, 1'b0, 16'h0080, 16'h00C0);
    chk_log("R4 opr", 1, 1'b0, 16'h00C0, 16'h0007);
    chk_log("R4 res", 2, 1'b1, 16'h00C0, 16'h0008);
    check("R4 pc count", 16'(pcl_n), 16'd1);
    check("R4 pc", pcl[0], 16'h0082);
  endtask

  task automatic t_indexed(input logic [15:0] base, input logic [15:0] disp,
                           input logic [15:0] ea);
    mem[16'h0044 >> 1] = base; mem[16'h0080 >> 1] = disp;
    mem[ea[7:1]] = 16'h0010; fn_sel = 0;
    run_op(2'b10, 4'd2, 2'b00);
    check("R5 count", 16'(lg_n), 16'd4);
    chk_log("R5 ext first", 0, 1'b0, 16'h0080, disp);
    chk_log("R5 reg", 1, 1'b0, 16'h0044, base);
    chk_log("R5 opr", 2, 1'b0, ea, 16'h0010);
    chk_log("R5 res", 3, 1'b1, ea, 16'h0011);
  endtask

  task automatic t_write_only;
    mem[16'h0046 >> 1] = 16'h00A0; mem[16'h00A0 >> 1] = 16'h1111; fn_sel = 2;
    seen_opnd = 16'h5555;
    run_op(2'b01, 4'd3, 2'b01);
    check("R7 count", 16'(lg_n), 16'd2);
    chk_log("R7 reg", 0, 1'b0, 16'h0046, 16'h00A0);
    chk_log("R7 write", 1, 1'b1, 16'h00A0, 16'hFFFF);
    check("R7 operand zero", seen_opnd, 16'h0000);
  endtask

  task automatic t_branch;
    mem[16'h0080 >> 1] = 16'h00D0;
    run_op(2'b10, 4'd0, 2'b10);
    check("R8 count", 16'(lg_n), 16'd1);
    check("R8 no write", {15'd0, lg_wr[0]}, 16'd0);
    check("R8 pc count", 16'(pcl_n), 16'd2);
    check("R8 pc ext", pcl[0], 16'h0082);
    check("R8 pc target", pcl[1], 16'h00D0);
  endtask

  task automatic t_link_ind;
    mem[16'h0048 >> 1] = 16'h00E0;
    run_op(2'b01, 4'd4, 2'b11);
    check("R9 count", 16'(lg_n), 16'd2);
    chk_log("R9 link", 1, 1'b1, 16'h0056, 16'h0080);
    check("R9 pc count", 16'(pcl_n), 16'd1);
    check("R9 pc", pcl[0], 16'h00E0);
  endtask

  task automatic t_link_abs;
    mem[16'h0080 >> 1] = 16'h00E4;
    run_op(2'b10, 4'd0, 2'b11);
    check("R9 abs count", 16'(lg_n), 16'd2);
    chk_log("R9 abs link", 1, 1'b1, 16'h0056, 16'h0082);
    check("R9 abs pc", pcl[1], 16'h00E4);
  endtask

  task automatic t_busy_start;
    mem[16'h004A >> 1] = 16'h0020; fn_sel = 0; ws = 3;
    lg_n = 0; pcl_n = 0; done_cnt = 0;
    @(negedge clk);
    mode_i = 2'b00; reg_i = 4'd5; kind_i = 2'b00; start = 1'b1;
    @(negedge clk);
    check("R11 busy", {15'd0, busy}, 16'd1);
    mode_i = 2'b10; reg_i = 4'd0; kind_i = 2'b10;
    repeat (3) @(negedge clk);
    start = 1'b0;
    for (int t = 0; t < 200 && !done; t++) @(negedge clk);
    check("R11 done width", {15'd0, done}, 16'd1);
    @(negedge clk);
    check("R11 done once", 16'(done_cnt), 16'd1);
    check("R11 idle", {15'd0, busy}, 16'd0);
    check("R11 ignored start", 16'(lg_n), 16'd2);
    check("R11 result", mem[16'h004A >> 1], 16'h0021);
    ws = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    for (int i = 0; i < 128; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    @(negedge clk);
    t_register;
    t_indirect;
    t_autoinc;
    t_absolute;
    t_indexed(16'h00C4, 16'h0004, 16'h00C8);
    t_indexed(16'hFFFE, 16'h0004, 16'h0002);
    t_write_only;
    t_branch;
    t_link_ind;
    t_link_abs;
    t_busy_start;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule